// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits between a memory command scheduler and the SDRAM command pins. It watches every command that actually goes out (activate, read, write, precharge, with the bank number and the address bit that selects auto-precharge or precharge-all). From that stream it keeps, for each bank, a small state and a countdown timer. It also keeps one shared timer that spaces activates to different banks. From these it tells the scheduler, in every cycle, which commands each bank may legally accept in that same cycle.

The scheduler reads the allow vectors, picks a command that is allowed, and drives it back on the command inputs. A read or write with auto-precharge is modelled as an internal precharge. That precharge begins one burst length after the column command and then holds the bank closed for the precharge period. Reads and writes share one allow vector, because every timing rule enforced here treats them alike. A command presented while it is not allowed is dropped, so the tracked state always describes legal traffic. All timing values are parameters, counted in clock cycles. Reset puts every bank in the idle state.

Top module: `sdram_bank_guard`

## Requirements
- R1: The command input is coded 0 = no operation, 1 = activate, 2 = read, 3 = write, 4 = precharge. Codes 5, 6 and 7 act as no operation and change no allow output.
- R2: During and right after reset, every bank is idle: activate and precharge are allowed on all banks, precharge-all is allowed, and read/write is allowed on none.
- R3: After an activate in cycle t, no activate to any bank is allowed before cycle t+T_RRD. Banks that are idle may take one from cycle t+T_RRD.
- R4: After an activate to a bank in cycle t, read/write to that bank is allowed from cycle t+T_RCD and not earlier. It then stays allowed while the bank is open.
- R5: After an activate to a bank in cycle t, precharge of that bank is allowed from cycle t+T_RAS and not earlier.
- R6: After a precharge closes an open bank in cycle t, a new activate to that bank is allowed from cycle t+T_RP and not earlier. Read, write and precharge to it stay blocked meanwhile.
- R7: A read or write with address bit 10 high in cycle t blocks read, write, precharge and activate to that bank. The block lasts until activate becomes allowed in cycle t+BURST_LEN+T_RP.
- R8: Precharge-all (precharge with bit 10 high, bank ignored) is allowed only when every bank would accept a single-bank precharge. It closes every open bank at once, and each one then follows the R6 timing.
- R9: A command issued while its allow output for the addressed bank is low is ignored and changes no state.
- R10: A precharge to an idle bank is allowed and leaves the bank idle, so activate stays allowed.
- R11: The parameters must satisfy T_RCD + BURST_LEN > T_RAS. This is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command issued this cycle (R1 coding) |
| bank_i | input | BW = log2(NB) | Bank addressed by the command |
| a10_i | input | 1 | Auto-precharge for read/write; all banks for precharge |
| act_ok_o | output | NB | Per-bank activate allowed this cycle |
| rw_ok_o | output | NB | Per-bank read/write allowed this cycle |
| pre_ok_o | output | NB | Per-bank precharge allowed this cycle |
| prea_ok_o | output | 1 | Precharge-all allowed this cycle |

## Verification
A bank whose state or timer is wrong shows up in its allow bits in the very next cycle, because every allow output is decoded straight from registered state. A timer loaded with the wrong value moves the first allowed cycle of that bank by the same number of cycles. The bench therefore checks the allow outputs in every cycle of each window, not only at its end, so an early or late release is caught in the cycle it happens. A missed phase change, such as an auto-precharge that never starts, leaves the bank blocked forever. That shows up as activate never returning at cycle t+BURST_LEN+T_RP.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sdg_cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_AUTOPRE = 2'd2,
    BK_CLOSING = 2'd3
  } bank_st_e;

  // A rule "allowed n cycles after" is met when a countdown loaded with n-1
  // at the command edge reaches zero.
  function automatic int hold_cycles(int n);
    return (n > 1) ? n - 1 : 0;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Width of a countdown that has to hold the largest timing value.
  function automatic int timer_width(int a, int b, int c, int d);
    int m;
    m = max_of(max_of(a, b), max_of(c, d));
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/sdg_act_spacer.sv
module sdg_act_spacer #(
  parameter int T_RRD = 2,
  localparam int RW = (T_RRD < 2) ? 1 : $clog2(T_RRD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_any,
  output logic spaced_ok
);
  import sdg_pkg::*;

  localparam logic [RW-1:0] LD_RRD = RW'(hold_cycles(T_RRD));

  logic [RW-1:0] gap_tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_tmr <= '0;
    end else if (act_any) begin
      gap_tmr <= LD_RRD;
    end else if (gap_tmr != '0) begin
      gap_tmr <= gap_tmr - 1'b1;
    end
  end

  assign spaced_ok = (gap_tmr == '0);

endmodule

// File: rtl/sdg_bank_timer.sv
module sdg_bank_timer #(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  parameter int CW        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic rw_go,
  input  logic ap_req,
  input  logic pre_go,
  output logic act_rdy,
  output logic rw_rdy,
  output logic pre_rdy,
  output logic is_open
);
  import sdg_pkg::*;

  localparam logic [CW-1:0] LD_RCD = CW'(hold_cycles(T_RCD));
  localparam logic [CW-1:0] LD_RAS = CW'(hold_cycles(T_RAS));
  localparam logic [CW-1:0] LD_RP  = CW'(hold_cycles(T_RP));
  localparam logic [CW-1:0] LD_BL  = CW'(hold_cycles(BURST_LEN));

  bank_st_e      st;
  logic [CW-1:0] tmr;      // tRCD, then burst wait, then tRP
  logic [CW-1:0] ras_tmr;  // activate-to-precharge window
  logic          tmr_zero;

  assign tmr_zero = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BK_IDLE;
      tmr     <= '0;
      ras_tmr <= '0;
    end else begin
      if (tmr != '0)     tmr     <= tmr - 1'b1;
      if (ras_tmr != '0) ras_tmr <= ras_tmr - 1'b1;
      case (st)
        BK_IDLE: begin
          if (act_go) begin
            st      <= BK_OPEN;
            tmr     <= LD_RCD;
            ras_tmr <= LD_RAS;
          end
        end
        BK_OPEN: begin
          if (pre_go) begin
            st  <= BK_CLOSING;
            tmr <= LD_RP;
          end else if (rw_go && ap_req) begin
            st  <= BK_AUTOPRE;
            tmr <= LD_BL;
          end
        end
        BK_AUTOPRE: begin
          if (tmr_zero) begin
            st  <= BK_CLOSING;
            tmr <= LD_RP;
          end
        end
        BK_CLOSING: begin
          if (act_go) begin
            st      <= BK_OPEN;
            tmr     <= LD_RCD;
            ras_tmr <= LD_RAS;
          end else if (tmr_zero) begin
            st <= BK_IDLE;
          end
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  assign act_rdy = (st == BK_IDLE) || (st == BK_CLOSING && tmr_zero);
  assign rw_rdy  = (st == BK_OPEN) && tmr_zero;
  assign pre_rdy = (st == BK_IDLE) || (st == BK_OPEN && ras_tmr == '0);
  assign is_open = (st == BK_OPEN);

endmodule

// File: rtl/sdg_cmd_decode.sv
module sdg_cmd_decode #(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic [2:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic          a10_i,
  input  logic [NB-1:0] act_ok,
  input  logic [NB-1:0] rw_ok,
  input  logic [NB-1:0] pre_ok,
  input  logic          prea_ok,
  output logic [NB-1:0] act_fire,
  output logic [NB-1:0] rw_fire,
  output logic [NB-1:0] ap_fire,
  output logic [NB-1:0] pre_fire
);
  import sdg_pkg::*;

  logic is_act, is_rw, is_pre;

  assign is_act = (cmd_i == CMD_ACT);
  assign is_rw  = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign is_pre = (cmd_i == CMD_PRE);

  for (genvar b = 0; b < NB; b++) begin : g_sel
    logic hit;
    assign hit         = (bank_i == BW'(b));
    assign act_fire[b] = is_act && hit && act_ok[b];
    assign rw_fire[b]  = is_rw && hit && rw_ok[b];
    assign ap_fire[b]  = rw_fire[b] && a10_i;
    assign pre_fire[b] = is_pre && (a10_i ? prea_ok : (hit && pre_ok[b]));
  end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard #(
  parameter int NB        = 4,
  parameter int T_RRD     = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  localparam int BW = $clog2(NB),
  localparam int CW = sdg_pkg::timer_width(T_RCD, T_RAS, T_RP, BURST_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic          a10_i,
  output logic [NB-1:0] act_ok_o,
  output logic [NB-1:0] rw_ok_o,
  output logic [NB-1:0] pre_ok_o,
  output logic          prea_ok_o
);

  logic [NB-1:0] act_rdy, rw_rdy, pre_rdy, bank_open;
  logic [NB-1:0] act_fire, rw_fire, ap_fire, pre_fire;
  logic [NB-1:0] close_start;  // precharge that actually closes an open bank
  logic          spaced_ok;

  sdg_cmd_decode #(.NB(NB)) u_dec (
    .cmd_i   (cmd_i),
    .bank_i  (bank_i),
    .a10_i   (a10_i),
    .act_ok  (act_ok_o),
    .rw_ok   (rw_ok_o),
    .pre_ok  (pre_ok_o),
    .prea_ok (prea_ok_o),
    .act_fire(act_fire),
    .rw_fire (rw_fire),
    .ap_fire (ap_fire),
    .pre_fire(pre_fire)
  );

  sdg_act_spacer #(.T_RRD(T_RRD)) u_rrd (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_any  (|act_fire),
    .spaced_ok(spaced_ok)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdg_bank_timer #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .BURST_LEN(BURST_LEN), .CW(CW)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_go (act_fire[b]),
      .rw_go  (rw_fire[b]),
      .ap_req (ap_fire[b]),
      .pre_go (pre_fire[b]),
      .act_rdy(act_rdy[b]),
      .rw_rdy (rw_rdy[b]),
      .pre_rdy(pre_rdy[b]),
      .is_open(bank_open[b])
    );
  end

  assign act_ok_o    = act_rdy & {NB{spaced_ok}};
  assign rw_ok_o     = rw_rdy;
  assign pre_ok_o    = pre_rdy;
  assign prea_ok_o   = &pre_rdy;
  assign close_start = pre_fire & bank_open;

endmodule

// File: rtl/sdg_guard_chk.sv
module sdg_guard_chk #(
  parameter int NB        = 4,
  parameter int T_RRD     = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd_i,
  input logic          a10_i,
  input logic [NB-1:0] act_ok,
  input logic [NB-1:0] rw_ok,
  input logic [NB-1:0] pre_ok,
  input logic          prea_ok,
  input logic [NB-1:0] act_fire,
  input logic [NB-1:0] ap_fire,
  input logic [NB-1:0] close_start
);

  // R11: parameter set must leave the activate-to-precharge window covered
  initial begin
    p_cfg_window_r11: assert (T_RCD + BURST_LEN > T_RAS)
      else $error("timing parameters break T_RCD+BURST_LEN > T_RAS");
  end

  p_rrd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|act_fire) && (T_RRD > 1)) |=> (act_ok == '0));

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|act_fire) && (T_RCD > 1)) |=> ((rw_ok & $past(act_fire)) == '0));

  p_ras_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|act_fire) && (T_RAS > 1)) |=> ((pre_ok & $past(act_fire)) == '0));

  p_rp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|close_start) && (T_RP > 1)) |=> ((act_ok & $past(close_start)) == '0));

  p_ap_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ap_fire) |=> (((act_ok | rw_ok | pre_ok) & $past(ap_fire)) == '0));

  p_prea_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd4) && a10_i && prea_ok) |=> (rw_ok == '0));

endmodule

bind sdram_bank_guard sdg_guard_chk #(
  .NB(NB), .T_RRD(T_RRD), .T_RCD(T_RCD), .T_RAS(T_RAS),
  .T_RP(T_RP), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_i      (cmd_i),
  .a10_i      (a10_i),
  .act_ok     (act_ok_o),
  .rw_ok      (rw_ok_o),
  .pre_ok     (pre_ok_o),
  .prea_ok    (prea_ok_o),
  .act_fire   (act_fire),
  .ap_fire    (ap_fire),
  .close_start(close_start)
);

// File: tb/sim_sdram_bank_guard.sv
module sim_sdram_bank_guard;

  localparam int CLK_P = 10;
  localparam int NB    = 4;
  localparam int TRRD  = 2;
  localparam int TRCD  = 3;
  localparam int TRAS  = 5;
  localparam int TRP   = 3;
  localparam int BL    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic       a10 = 1'b0;
  logic [3:0] act_ok, rw_ok, pre_ok;
  logic       prea_ok;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_bank_guard #(
    .NB(NB), .T_RRD(TRRD), .T_RCD(TRCD), .T_RAS(TRAS),
    .T_RP(TRP), .BURST_LEN(BL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .a10_i(a10),
    .act_ok_o(act_ok), .rw_ok_o(rw_ok), .pre_ok_o(pre_ok), .prea_ok_o(prea_ok)
  );

  // One row per cycle: the outputs expected in that cycle, then the command
  // issued in it. Masks are bank3..bank0.
  typedef struct packed {
    logic [2:0] cmd;
    logic [1:0] bank;
    logic       a10;
    logic [3:0] act;
    logic [3:0] rw;
    logic [3:0] pre;
    logic       prea;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    '{3'd1, 2'd0, 1'b0, 4'b1111, 4'b0000, 4'b1111, 1'b1, 4'd2},  // R2 idle, ACT b0
    '{3'd1, 2'd1, 1'b0, 4'b0000, 4'b0000, 4'b1110, 1'b0, 4'd9},  // R9 ACT b1 too early
    '{3'd1, 2'd1, 1'b0, 4'b1110, 4'b0000, 4'b1110, 1'b0, 4'd3},  // R3 ACT b1 at t+TRRD
    '{3'd2, 2'd0, 1'b0, 4'b0000, 4'b0001, 4'b1100, 1'b0, 4'd4},  // R4 read b0 at t+TRCD
    '{3'd0, 2'd0, 1'b0, 4'b1100, 4'b0001, 4'b1100, 1'b0, 4'd4},  // R4
    '{3'd3, 2'd1, 1'b1, 4'b1100, 4'b0011, 4'b1101, 1'b0, 4'd5},  // R5 b0 pre ok; WR+AP b1
    '{3'd4, 2'd0, 1'b0, 4'b1100, 4'b0001, 4'b1101, 1'b0, 4'd5},  // R5 PRE b0
    '{3'd0, 2'd0, 1'b0, 4'b1100, 4'b0000, 4'b1100, 1'b0, 4'd6},  // R6
    '{3'd0, 2'd0, 1'b0, 4'b1100, 4'b0000, 4'b1100, 1'b0, 4'd6},  // R6
    '{3'd0, 2'd0, 1'b0, 4'b1101, 4'b0000, 4'b1100, 1'b0, 4'd6},  // R6 b0 act at t+TRP
    '{3'd2, 2'd1, 1'b0, 4'b1101, 4'b0000, 4'b1101, 1'b0, 4'd9},  // R9 read to closing b1
    '{3'd0, 2'd0, 1'b0, 4'b1101, 4'b0000, 4'b1101, 1'b0, 4'd7},  // R7
    '{3'd1, 2'd2, 1'b0, 4'b1111, 4'b0000, 4'b1101, 1'b0, 4'd7},  // R7 b1 act at t+BL+TRP
    '{3'd1, 2'd3, 1'b0, 4'b0000, 4'b0000, 4'b1011, 1'b0, 4'd3},  // R3 spacing blocks b3
    '{3'd1, 2'd3, 1'b0, 4'b1011, 4'b0000, 4'b1011, 1'b0, 4'd3},  // R3
    '{3'd0, 2'd0, 1'b0, 4'b0000, 4'b0100, 4'b0011, 1'b0, 4'd4},  // R4
    '{3'd0, 2'd0, 1'b0, 4'b0011, 4'b0100, 4'b0011, 1'b0, 4'd5},  // R5
    '{3'd0, 2'd0, 1'b0, 4'b0011, 4'b1100, 4'b0111, 1'b0, 4'd5},  // R5
    '{3'd0, 2'd0, 1'b0, 4'b0011, 4'b1100, 4'b0111, 1'b0, 4'd8},  // R8 not yet all
    '{3'd4, 2'd0, 1'b1, 4'b0011, 4'b1100, 4'b1111, 1'b1, 4'd8},  // R8 precharge-all
    '{3'd0, 2'd0, 1'b0, 4'b0011, 4'b0000, 4'b0011, 1'b0, 4'd8},  // R8
    '{3'd0, 2'd0, 1'b0, 4'b0011, 4'b0000, 4'b0011, 1'b0, 4'd8},  // R8
    '{3'd0, 2'd0, 1'b0, 4'b1111, 4'b0000, 4'b0011, 1'b0, 4'd8},  // R8
    '{3'd4, 2'd1, 1'b0, 4'b1111, 4'b0000, 4'b1111, 1'b1, 4'd10}, // R10 PRE idle b1
    '{3'd7, 2'd0, 1'b1, 4'b1111, 4'b0000, 4'b1111, 1'b1, 4'd1},  // R1 code 7
    '{3'd5, 2'd2, 1'b0, 4'b1111, 4'b0000, 4'b1111, 1'b1, 4'd1}   // R1 code 5
  };

  task automatic check(input int req, input logic [12:0] got, input logic [12:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d t=%0t got act/rw/pre/all=%b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic a);
    cmd  = c;
    bank = b;
    a10  = a;
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R2: state held in reset
    repeat (2) @(negedge clk);
    #1 check(2, {act_ok, rw_ok, pre_ok, prea_ok}, {4'b1111, 4'b0000, 4'b1111, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].cmd, VT[i].bank, VT[i].a10);
      #1 check(int'(VT[i].req), {act_ok, rw_ok, pre_ok, prea_ok},
               {VT[i].act, VT[i].rw, VT[i].pre, VT[i].prea});
      @(negedge clk);
    end
    drive(3'd0, 2'd0, 1'b0);

    // R7: read with auto-precharge, every cycle of the window checked on bank 3
    @(negedge clk);
    drive(3'd1, 2'd3, 1'b0);
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0);
    repeat (TRCD - 1) @(negedge clk);
    #1 check(4, {9'd0, rw_ok[3], 3'd0}, {9'd0, 1'b1, 3'd0});  // R4 open at t+TRCD
    drive(3'd2, 2'd3, 1'b1);
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0);
    for (int k = 1; k <= BL + TRP; k++) begin
      #1 check(7, {10'd0, act_ok[3], rw_ok[3], pre_ok[3]},
               {10'd0, (k == BL + TRP), 1'b0, 1'b0});
      @(negedge clk);
    end

    // R2: reset while banks are busy returns all to idle
    drive(3'd1, 2'd0, 1'b0);
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0);
    rst_n = 1'b0;
    #1 check(2, {act_ok, rw_ok, pre_ok, prea_ok}, {4'b1111, 4'b0000, 4'b1111, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(2, {act_ok, rw_ok, pre_ok, prea_ok}, {4'b1111, 4'b0000, 4'b1111, 1'b1});

    // R11: the configuration used here keeps the window rule
    check(11, {12'd0, (TRCD + BL > TRAS)}, 13'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule